// File: doc/BRIEF.md
# Feed-Protected Clock Multiplier Control Registers

This block is a small memory-mapped register slave that stores the settings of an on-chip clock multiplier: an enable, a connect request, a multiplier field and a post-divider code. Software writes these values into shadow registers. None of them reaches the clock-generation logic until an unlock pair of writes lands on the feed register. A stray store therefore cannot reprogram the clock tree.

The committed (active) settings drive the clock generator directly. A lock flag models the loop settling. By default the flag comes from an internal delay counter. A parameter can instead take it from an external lock input. The connect output is held low until the active enable is set and lock is reported. This supports the usual bring-up flow: commit a configuration with enable set, poll the lock flag, then commit enable together with connect.

Top module: `clkmul_regs`

## Requirements
- R1: After reset, every output is 0. A read at offsets 0x0, 0x4, 0x8 and 0xC returns 0. The feed unlock sequence is idle.
- R2: Offset 0x0 is control, with bit 0 = enable and bit 1 = connect. Offset 0x4 is configuration, with bits [4:0] = multiplier minus one and bits [6:5] = divider code (0→1, 1→2, 2→4, 3→8). Control and configuration read back their shadow values with all other bits 0. Feed (0xC) always reads 0.
- R3: A write to control or configuration changes only the shadow value. The outputs pllEnable, pllConnect, pllMsel and pllPsel and the status register keep their values until a commit.
- R4: A commit happens when a write of 0x0000_00AA to feed is followed by a write of 0x0000_0055 to feed as the very next bus write. Idle cycles between the two writes are allowed. On commit, the active settings take the shadow values, and the outputs show them from the cycle after the 0x55 write.
- R5: An armed sequence is aborted, with no commit, by any bus write to another offset or by a feed write of any value other than 0xAA or 0x55. A 0x55 write without a preceding armed 0xAA does nothing. The sequence can then restart from 0xAA.
- R6: Status (offset 0x8) reads as follows: bits [6:0] = active configuration, bit 8 = active enable, bit 9 = the pllConnect output, bit 10 = lock. All other bits are 0. Writes to status have no effect.
- R7: The lock flag clears in two cases: a commit whose new enable is 0, and a commit whose configuration differs from the active one. With the default internal model, lock sets exactly LockCycles clock cycles after such a commit, or after a commit that turns enable on, provided the active enable stays 1. A commit with enable 1 and an unchanged configuration leaves lock and its count untouched.
- R8: pllConnect is 1 only when the committed connect bit, the active enable and lock are all 1. Otherwise it is 0. This includes a committed connect bit with enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset of the access |
| busWe | input | 1 | Write strobe, one write per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| lockIn | input | 1 | External lock indication (used only when ExtLock = 1) |
| pllEnable | output | 1 | Active enable |
| pllConnect | output | 1 | Gated connect to the clock generator |
| pllMsel | output | 5 | Active multiplier minus one |
| pllPsel | output | 2 | Active divider code |

## Verification
Directed sequences first walk the bring-up flow: connect is committed together with enable, and the bench checks that connect stays low until lock, which appears exactly on the programmed cycle count. Further directed cases separate a real commit from near misses: a configuration write between the two keys, a wrong feed value, a lone 0x55, and idle gaps between the keys. Other cases separate a lock-preserving recommit from a configuration change and from a disable. A seeded random phase then mixes writes to all four offsets, with the feed keys weighted up and idle cycles interleaved. After every cycle each output and the status word are compared against a bench model of the shadow, active and lock state.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;
  localparam int MselW = 5;
  localparam int PselW = 2;
  localparam int CfgW  = MselW + PselW;

  localparam logic [3:0] OffCtrl = 4'h0;
  localparam logic [3:0] OffCfg  = 4'h4;
  localparam logic [3:0] OffStat = 4'h8;
  localparam logic [3:0] OffFeed = 4'hC;

  localparam logic [31:0] KeyFirst  = 32'h0000_00AA;
  localparam logic [31:0] KeySecond = 32'h0000_0055;

  localparam int BitEn      = 0;
  localparam int BitConn    = 1;
  localparam int StatEnBit  = 8;
  localparam int StatConBit = 9;
  localparam int StatLkBit  = 10;

  typedef struct packed {
    logic wrCtrl;
    logic wrCfg;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/clkmul_ctrl.sv
module clkmul_ctrl
  import clkmul_pkg::*;
#(
  parameter int AddrW = 4,
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWe,
  input  logic [DataW-1:0] busWdata,
  output strobe_t          strb
);
  logic feedArmed;
  logic isFeed;
  logic keyA;
  logic keyB;

  assign isFeed = busWe && (busAddr == AddrW'(OffFeed));
  assign keyA   = (busWdata == DataW'(KeyFirst));
  assign keyB   = (busWdata == DataW'(KeySecond));

  always_comb begin
    strb        = '0;
    strb.wrCtrl = busWe && (busAddr == AddrW'(OffCtrl));
    strb.wrCfg  = busWe && (busAddr == AddrW'(OffCfg));
    strb.commit = isFeed && keyB && feedArmed;
  end

  // any write re-evaluates the sequence; only a first key leaves it armed
  always_ff @(posedge clk) begin
    if (!rstN)      feedArmed <= 1'b0;
    else if (busWe) feedArmed <= isFeed && keyA;
  end

  p_commit_disarms_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !feedArmed);
  p_other_write_aborts_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !isFeed) |=> !strb.commit);
  p_wrong_key_aborts_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isFeed && !keyA) |=> !strb.commit);
endmodule

// File: rtl/clkmul_datapath.sv
module clkmul_datapath
  import clkmul_pkg::*;
#(
  parameter int AddrW      = 4,
  parameter int DataW      = 32,
  parameter int LockCycles = 16,
  parameter bit ExtLock    = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [AddrW-1:0] busAddr,
  input  logic [CfgW-1:0]  wrData,
  input  logic             lockIn,
  output logic [DataW-1:0] rdData,
  output logic             pllEnable,
  output logic             pllConnect,
  output logic [MselW-1:0] pllMsel,
  output logic [PselW-1:0] pllPsel
);
  localparam int CntW = $clog2(LockCycles + 1);

  logic            shadowEn, shadowConn;
  logic [CfgW-1:0] shadowCfg;
  logic            activeEn, activeConnReq;
  logic [CfgW-1:0] activeCfg;
  logic            lockFlag;
  logic            cfgChange;

  assign cfgChange = (shadowCfg != activeCfg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowEn   <= 1'b0;
      shadowConn <= 1'b0;
      shadowCfg  <= '0;
    end else begin
      if (strb.wrCtrl) begin
        shadowEn   <= wrData[BitEn];
        shadowConn <= wrData[BitConn];
      end
      if (strb.wrCfg) shadowCfg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeEn      <= 1'b0;
      activeConnReq <= 1'b0;
      activeCfg     <= '0;
    end else if (strb.commit) begin
      activeEn      <= shadowEn;
      activeConnReq <= shadowConn;
      activeCfg     <= shadowCfg;
    end
  end

  generate
    if (ExtLock) begin : g_ext_lock
      assign lockFlag = activeEn && lockIn;
    end else begin : g_cnt_lock
      logic [CntW-1:0] lockCnt;
      logic            unusedLockIn;
      assign unusedLockIn = lockIn;

      always_ff @(posedge clk) begin
        if (!rstN)                                    lockCnt <= '0;
        else if (strb.commit && (!shadowEn || cfgChange)) lockCnt <= '0;
        else if (!activeEn)                           lockCnt <= '0;
        else if (lockCnt != CntW'(LockCycles))        lockCnt <= lockCnt + 1'b1;
      end
      assign lockFlag = activeEn && (lockCnt == CntW'(LockCycles));

      p_lock_needs_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
        $rose(lockFlag) |-> $past(activeEn));
      p_cfg_change_unlocks_r7: assert property (@(posedge clk) disable iff (!rstN)
        (strb.commit && cfgChange) |=> !lockFlag);
    end
  endgenerate

  assign pllEnable  = activeEn;
  assign pllConnect = activeConnReq && activeEn && lockFlag;
  assign pllMsel    = activeCfg[MselW-1:0];
  assign pllPsel    = activeCfg[CfgW-1:MselW];

  always_comb begin
    rdData = '0;
    case (busAddr)
      AddrW'(OffCtrl): begin
        rdData[BitEn]   = shadowEn;
        rdData[BitConn] = shadowConn;
      end
      AddrW'(OffCfg):  rdData[CfgW-1:0] = shadowCfg;
      AddrW'(OffStat): begin
        rdData[CfgW-1:0]  = activeCfg;
        rdData[StatEnBit] = activeEn;
        rdData[StatConBit] = pllConnect;
        rdData[StatLkBit] = lockFlag;
      end
      default: rdData = '0;
    endcase
  end

  p_hold_without_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(activeCfg) && $stable(activeEn) && $stable(activeConnReq)));
  p_commit_loads_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (activeCfg == $past(shadowCfg)));
  p_disable_drops_connect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !shadowEn) |=> !pllConnect);
endmodule

// File: rtl/clkmul_regs.sv
module clkmul_regs
  import clkmul_pkg::*;
#(
  parameter int AddrW      = 4,
  parameter int DataW      = 32,
  parameter int LockCycles = 16,
  parameter bit ExtLock    = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWe,
  input  logic [DataW-1:0] busWdata,
  output logic [DataW-1:0] busRdata,
  input  logic             lockIn,
  output logic             pllEnable,
  output logic             pllConnect,
  output logic [MselW-1:0] pllMsel,
  output logic [PselW-1:0] pllPsel
);
  strobe_t strb;

  clkmul_ctrl #(.AddrW(AddrW), .DataW(DataW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strb(strb)
  );

  clkmul_datapath #(.AddrW(AddrW), .DataW(DataW), .LockCycles(LockCycles),
                    .ExtLock(ExtLock)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .wrData(busWdata[CfgW-1:0]), .lockIn(lockIn), .rdData(busRdata),
    .pllEnable(pllEnable), .pllConnect(pllConnect),
    .pllMsel(pllMsel), .pllPsel(pllPsel)
  );
endmodule

// File: tb/clkmul_regs_tb.sv
module clkmul_regs_tb;
  localparam int LOCK = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        lockIn = 1'b0;
  logic        pllEnable, pllConnect;
  logic [4:0]  pllMsel;
  logic [1:0]  pllPsel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference state
  logic [1:0] mShCtrl;
  logic [6:0] mShCfg;
  logic       mArmed;
  logic       mEn, mConnReq;
  logic [6:0] mCfg;
  int         mCnt;

  always #5 clk = ~clk;

  clkmul_regs #(.LockCycles(LOCK)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .lockIn(lockIn),
    .pllEnable(pllEnable), .pllConnect(pllConnect),
    .pllMsel(pllMsel), .pllPsel(pllPsel)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic modelReset();
    mShCtrl = '0; mShCfg = '0; mArmed = 0; mEn = 0; mConnReq = 0; mCfg = '0; mCnt = 0;
  endtask

  function automatic bit mLock();
    return mEn && (mCnt == LOCK);
  endfunction

  function automatic logic [31:0] expStatus();
    logic [31:0] s;
    s = '0;
    s[6:0] = mCfg;
    s[8]   = mEn;
    s[9]   = mConnReq && mEn && mLock();
    s[10]  = mLock();
    return s;
  endfunction

  task automatic modelStep(input logic we, input logic [3:0] a, input logic [31:0] d);
    bit commit;
    bit isFeed;
    commit = we && a == 4'hC && d == 32'h55 && mArmed;
    isFeed = we && a == 4'hC;
    if (commit && (!mShCtrl[0] || mShCfg != mCfg)) mCnt = 0;
    else if (!mEn) mCnt = 0;
    else if (mCnt != LOCK) mCnt++;
    if (commit) begin
      mEn = mShCtrl[0]; mConnReq = mShCtrl[1]; mCfg = mShCfg;
    end
    if (we && a == 4'h0) mShCtrl = d[1:0];
    if (we && a == 4'h4) mShCfg = d[6:0];
    if (we) mArmed = isFeed && d == 32'hAA;
  endtask

  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d);
    busWe = we; busAddr = a; busWdata = d;
    @(posedge clk);
    modelStep(we, a, d);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, 32'h0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    busWe = 1'b0; busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic checkAll(input string phase);
    logic [31:0] v;
    chk({phase, " R4 enable"}, 32'(pllEnable), 32'(mEn));
    chk({phase, " R4 msel"}, 32'(pllMsel), 32'(mCfg[4:0]));
    chk({phase, " R4 psel"}, 32'(pllPsel), 32'(mCfg[6:5]));
    chk({phase, " R8 connect"}, 32'(pllConnect), 32'(mConnReq && mEn && mLock()));
    rd(4'h8, v);
    chk({phase, " R6 status"}, v, expStatus());
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 10 - 100);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] seedv;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 enable", 32'(pllEnable), 0);
    chk("R1 connect", 32'(pllConnect), 0);
    chk("R1 msel/psel", {25'd0, pllPsel, pllMsel}, 0);
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v);
      chk("R1 read", v, 0);
    end

    // R2 readback masks, R3 shadowing
    cyc(1, 4'h0, 32'hFFFF_FFFF); rd(4'h0, v); chk("R2 ctrl readback", v, 32'h3);
    cyc(1, 4'h4, 32'hFFFF_FFFF); rd(4'h4, v); chk("R2 cfg readback", v, 32'h7F);
    cyc(1, 4'hC, 32'hAA);        rd(4'hC, v); chk("R2 feed reads zero", v, 0);
    chk("R3 enable held", 32'(pllEnable), 0);
    rd(4'h8, v); chk("R3 status held", v, 0);

    // R5 abort by config write between keys, lone second key
    cyc(1, 4'h4, 32'h24);
    cyc(1, 4'hC, 32'h55);
    chk("R5 abort by cfg write", 32'(pllEnable), 0);
    cyc(1, 4'h0, 32'h3);
    cyc(1, 4'hC, 32'h55);
    chk("R5 lone second key", 32'(pllEnable), 0);

    // R4 commit, R8 connect waits for lock, R7 lock timing
    cyc(1, 4'hC, 32'hAA);
    cyc(1, 4'hC, 32'h55);
    chk("R4 enable after commit", 32'(pllEnable), 1);
    chk("R4 msel=4", 32'(pllMsel), 4);
    chk("R4 psel=1", 32'(pllPsel), 1);
    chk("R8 connect before lock", 32'(pllConnect), 0);
    idle(LOCK - 1);
    rd(4'h8, v); chk("R7 no lock at LOCK-1", v, 32'h124);
    chk("R8 connect still low", 32'(pllConnect), 0);
    idle(1);
    rd(4'h8, v); chk("R7 R6 locked status", v, 32'h724);
    chk("R8 connect after lock", 32'(pllConnect), 1);
    checkAll("directed");

    // R4 idle gap between keys, R7 same-config recommit keeps lock
    cyc(1, 4'hC, 32'hAA);
    idle(3);
    cyc(1, 4'hC, 32'h55);
    chk("R7 lock kept on same cfg", 32'(pllConnect), 1);

    // R5 wrong feed value aborts
    cyc(1, 4'h4, 32'h05);
    cyc(1, 4'hC, 32'hAA);
    cyc(1, 4'hC, 32'h12);
    cyc(1, 4'hC, 32'h55);
    chk("R5 wrong key no commit", 32'(pllMsel), 4);
    cyc(1, 4'hC, 32'hAA);
    cyc(1, 4'hC, 32'h55);
    chk("R5 restart commits", 32'(pllMsel), 5);
    rd(4'h8, v); chk("R7 cfg change clears lock", v, 32'h105);
    idle(LOCK);
    chk("R8 relock connect", 32'(pllConnect), 1);

    // R7/R8 disable with connect still requested
    cyc(1, 4'h0, 32'h2);
    cyc(1, 4'hC, 32'hAA);
    cyc(1, 4'hC, 32'h55);
    idle(LOCK + 2);
    rd(4'h8, v); chk("R7 disabled no lock", v, 32'h005);
    chk("R8 connect low when disabled", 32'(pllConnect), 0);
    cyc(1, 4'h8, 32'hFFFF_FFFF);
    rd(4'h8, v); chk("R6 status write ignored", v, 32'h005);
    checkAll("directed");

    // seeded random phase
    seedv = $urandom(32'd20240611);
    for (int i = 0; i < 4000; i++) begin
      int pick;
      logic [3:0]  a;
      logic [31:0] d;
      pick = $urandom_range(0, 9);
      a = 4'($urandom_range(0, 3) * 4);
      if ($urandom_range(0, 1) == 1) a = 4'hC;
      case ($urandom_range(0, 3))
        0: d = 32'hAA;
        1: d = 32'h55;
        2: d = 32'($urandom_range(0, 127));
        default: d = $urandom();
      endcase
      if (a == 4'h0 && $urandom_range(0, 3) != 0) d = 32'h1 | 32'($urandom_range(0, 1) << 1);
      if (pick < 4) cyc(1'b0, 4'h0, 32'h0);
      else cyc(1'b1, a, d);
      checkAll("random");
    end
    if (seedv == 32'hFFFF_FFFF) $display("seed marker");

    done = 1;
    summary();
    $finish;
  end
endmodule